// File: doc/BRIEF.md
# Transmit Cell Rate Decoupler

This block sits on the transmit side of a cell transmission convergence path. Upstream logic writes 53-byte cells (5 header bytes, then 48 payload bytes) one byte at a time over a valid/ready handshake. The line side asks for one byte per byte slot through a plain `slot_en` strobe. The block answers every slot with a byte, so the output never stalls. At each 53-byte boundary it sends a buffered user cell if one is complete. Otherwise it sends a fixed idle cell. Headers are assumed to be valid already: no header checksum is computed, and nothing is scrambled or framed here.

A second path serves a loopback receive stream. It looks at the first four bytes of every incoming cell. It discards the cell when they equal the idle pattern and passes every other cell upward unchanged. Two wrapping counters report how many idle cells were inserted on transmit and how many were removed on receive.

Back-pressure rules:
- Upstream may hold `in_valid` high for as long as it likes.
- A byte transfers on every rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` drops only while the byte buffer is full. It rises again as soon as the scheduler consumes a byte.
- The line side and the upward receive output have no back-pressure. They are strobed streams.

Top module: `cell_rate_decoupler`

## Requirements
- R1: On each rising edge where `slot_en` is high, the block emits one byte, and `tx_vld` is high for the following cycle. After an edge with `slot_en` low, `tx_vld` is low and `tx_data` holds its previous value.
- R2: The emitted stream is a sequence of whole 53-byte cells. `tx_soc` is high on the first byte of every cell, user or idle, and low on the other 52.
- R3: An idle cell is, in byte order, 0x00, 0x00, 0x00, 0x01, 0x52, followed by 48 bytes of 0x6A.
- R4: The choice between a user cell and an idle cell is made only at a cell boundary. A user cell is chosen only if all 53 of its bytes are already buffered, so a partly written cell gives an idle cell and is never split.
- R5: User cells leave in the order they were written, with every byte unchanged.
- R6: `in_ready` stays high while fewer than CELLS*53 bytes are buffered. With the default CELLS=2, exactly 106 bytes are accepted before `in_ready` falls.
- R7: `tx_idle_cnt` increments by one, on the same edge that emits the first byte of each inserted idle cell, and wraps from all ones to zero.
- R8: On the receive input, `rx_soc` marks the first byte of each cell. A cell whose first four bytes are 0x00 0x00 0x00 0x01 is dropped. Every other cell leaves on `up_data`/`up_valid`, unchanged and in order, with `up_soc` on its first byte. The output lags the input by four accepted bytes.
- R9: `rx_idle_cnt` increments by one for each dropped idle cell and wraps from all ones to zero.
- R10: After reset, `tx_vld` and `up_valid` are low, `in_ready` is high, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream byte is valid |
| in_ready | output | 1 | Buffer can accept a byte |
| in_data | input | 8 | Upstream cell byte |
| slot_en | input | 1 | Line byte slot request |
| tx_vld | output | 1 | Line byte emitted this cycle |
| tx_data | output | 8 | Line byte |
| tx_soc | output | 1 | First byte of a line cell |
| tx_idle_cnt | output | CNT_W | Inserted idle cells, wrapping |
| rx_valid | input | 1 | Loopback receive byte valid |
| rx_data | input | 8 | Loopback receive byte |
| rx_soc | input | 1 | First byte of a received cell |
| up_valid | output | 1 | Upward byte valid |
| up_data | output | 8 | Upward byte (idle cells removed) |
| up_soc | output | 1 | First byte of an upward cell |
| rx_idle_cnt | output | CNT_W | Removed idle cells, wrapping |

## Verification
Some properties hold on every cycle, and the assertions track them:
- one output byte per slot request;
- a start flag every 53 emitted bytes, on both the line output and the upward output;
- both counters moving only in single steps;
- the transmit counter moving only together with a start-of-cell byte.

Other behaviour depends on particular traffic, and only the bench scenarios can show it:
- whether a cell is user or idle, given how many bytes were buffered at a boundary;
- the exact idle byte pattern;
- that user bytes arrive unchanged and in order;
- the 106-byte buffer limit;
- that a near-idle header survives the receive filter.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int CELL_BYTES = 53;
  localparam int POS_W      = $clog2(CELL_BYTES);
  localparam int ID_BYTES   = 4;
  localparam logic [8*ID_BYTES-1:0] IDLE_HDR = 32'h0000_0001;
  localparam logic [7:0] IDLE_HEC = 8'h52;
  localparam logic [7:0] IDLE_FILL = 8'h6A;

  function automatic logic [7:0] idle_byte(input logic [POS_W-1:0] idx);
    logic [7:0] b;
    if (idx < POS_W'(ID_BYTES))
      b = IDLE_HDR[8*(ID_BYTES-1-int'(idx)) +: 8];
    else if (idx == POS_W'(ID_BYTES))
      b = IDLE_HEC;
    else
      b = IDLE_FILL;
    return b;
  endfunction
endpackage

// File: rtl/crd_byte_fifo.sv
module crd_byte_fifo #(
  parameter int DEPTH = 106
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] wdata,
  input  logic       pop,
  output logic [7:0] rdata,
  output logic       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/crd_tx_admit.sv
module crd_tx_admit
  import crd_pkg::*;
#(
  parameter int CELLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic fifo_full,
  input  logic commit,
  output logic in_ready,
  output logic push,
  output logic have_cell
);
  localparam int NW = $clog2(CELLS + 1);

  logic [POS_W-1:0] wr_pos;
  logic [NW-1:0]    ready_cells;
  logic             cell_done;

  assign in_ready  = !fifo_full;
  assign push      = in_valid && in_ready;
  assign cell_done = push && (wr_pos == POS_W'(CELL_BYTES - 1));
  assign have_cell = (ready_cells != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos      <= '0;
      ready_cells <= '0;
    end else begin
      if (push) wr_pos <= cell_done ? '0 : wr_pos + 1'b1;
      case ({cell_done, commit})
        2'b10:   ready_cells <= ready_cells + 1'b1;
        2'b01:   ready_cells <= ready_cells - 1'b1;
        default: ready_cells <= ready_cells;
      endcase
    end
  end
endmodule

// File: rtl/crd_tx_sched.sv
module crd_tx_sched
  import crd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_en,
  input  logic             have_cell,
  input  logic [7:0]       fifo_rdata,
  output logic             pop,
  output logic             commit,
  output logic             tx_vld,
  output logic [7:0]       tx_data,
  output logic             tx_soc,
  output logic [CNT_W-1:0] idle_cnt
);
  logic [POS_W-1:0] pos;
  logic             cur_user;
  logic             at_start;
  logic             byte_user;

  assign at_start  = (pos == '0);
  assign byte_user = at_start ? have_cell : cur_user;
  assign pop       = slot_en && byte_user;
  assign commit    = slot_en && at_start && have_cell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      cur_user <= 1'b0;
      tx_vld   <= 1'b0;
      tx_data  <= '0;
      tx_soc   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      tx_vld <= slot_en;
      if (slot_en) begin
        tx_data <= byte_user ? fifo_rdata : idle_byte(pos);
        tx_soc  <= at_start;
        pos     <= (pos == POS_W'(CELL_BYTES - 1)) ? '0 : pos + 1'b1;
        if (at_start) begin
          cur_user <= have_cell;
          if (!have_cell) idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crd_rx_filter.sv
module crd_rx_filter
  import crd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_soc,
  output logic             up_valid,
  output logic [7:0]       up_data,
  output logic             up_soc,
  output logic [CNT_W-1:0] idle_cnt
);
  localparam int STAGES = ID_BYTES;

  logic [7:0]        sd [STAGES];
  logic [STAGES-1:0] ss, sv, match;
  logic              drop_r, exit_idle, drop_now, leaving;

  for (genvar g = 0; g < STAGES; g++) begin : g_cmp
    assign match[g] = (sd[g] == IDLE_HDR[8*g +: 8]);
  end

  assign leaving   = rx_valid && sv[STAGES-1];
  assign exit_idle = ss[STAGES-1] && (&match) && (&sv);
  assign drop_now  = ss[STAGES-1] ? exit_idle : drop_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sd[i] <= '0;
      ss <= '0;
      sv <= '0;
    end else if (rx_valid) begin
      sd[0] <= rx_data;
      for (int i = 1; i < STAGES; i++) sd[i] <= sd[i-1];
      ss <= {ss[STAGES-2:0], rx_soc};
      sv <= {sv[STAGES-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_r   <= 1'b0;
      up_valid <= 1'b0;
      up_data  <= '0;
      up_soc   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      up_valid <= leaving && !drop_now;
      if (leaving) begin
        up_data <= sd[STAGES-1];
        up_soc  <= ss[STAGES-1];
        if (ss[STAGES-1]) begin
          drop_r <= exit_idle;
          if (exit_idle) idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cell_rate_decoupler.sv
module cell_rate_decoupler
  import crd_pkg::*;
#(
  parameter int CELLS = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             slot_en,
  output logic             tx_vld,
  output logic [7:0]       tx_data,
  output logic             tx_soc,
  output logic [CNT_W-1:0] tx_idle_cnt,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_soc,
  output logic             up_valid,
  output logic [7:0]       up_data,
  output logic             up_soc,
  output logic [CNT_W-1:0] rx_idle_cnt
);
  localparam int DEPTH = CELLS * CELL_BYTES;

  logic       push, pop, commit, full, have_cell;
  logic [7:0] fifo_rdata;

  crd_tx_admit #(.CELLS(CELLS)) u_admit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fifo_full(full),
    .commit(commit), .in_ready(in_ready), .push(push), .have_cell(have_cell)
  );

  crd_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data),
    .pop(pop), .rdata(fifo_rdata), .full(full)
  );

  crd_tx_sched #(.CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .have_cell(have_cell),
    .fifo_rdata(fifo_rdata), .pop(pop), .commit(commit), .tx_vld(tx_vld),
    .tx_data(tx_data), .tx_soc(tx_soc), .idle_cnt(tx_idle_cnt)
  );

  crd_rx_filter #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_soc(rx_soc), .up_valid(up_valid), .up_data(up_data),
    .up_soc(up_soc), .idle_cnt(rx_idle_cnt)
  );
endmodule

// File: rtl/crd_checker.sv
module crd_checker
  import crd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_en,
  input logic             tx_vld,
  input logic             tx_soc,
  input logic [CNT_W-1:0] tx_idle_cnt,
  input logic             up_valid,
  input logic             up_soc,
  input logic [CNT_W-1:0] rx_idle_cnt
);
  logic [POS_W-1:0] tx_pos, up_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pos <= '0;
      up_pos <= '0;
    end else begin
      if (tx_vld) tx_pos <= (tx_pos == POS_W'(CELL_BYTES - 1)) ? '0 : tx_pos + 1'b1;
      if (up_valid) up_pos <= (up_pos == POS_W'(CELL_BYTES - 1)) ? '0 : up_pos + 1'b1;
    end
  end

  AST_SLOT_GIVES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> tx_vld); // R1
  AST_NO_BYTE_WITHOUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !tx_vld); // R1
  AST_TX_CELL_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> (tx_soc == (tx_pos == '0))); // R2
  AST_TX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle_cnt != $past(tx_idle_cnt)) |-> (tx_idle_cnt == $past(tx_idle_cnt) + 1'b1)); // R7
  AST_TX_CNT_AT_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle_cnt != $past(tx_idle_cnt)) |-> (tx_vld && tx_soc)); // R7
  AST_UP_CELL_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (up_soc == (up_pos == '0))); // R8
  AST_RX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_idle_cnt != $past(rx_idle_cnt)) |-> (rx_idle_cnt == $past(rx_idle_cnt) + 1'b1)); // R9
endmodule

bind cell_rate_decoupler crd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .tx_vld(tx_vld),
  .tx_soc(tx_soc), .tx_idle_cnt(tx_idle_cnt), .up_valid(up_valid),
  .up_soc(up_soc), .rx_idle_cnt(rx_idle_cnt)
);

// File: tb/cell_rate_decoupler_tb.sv
module cell_rate_decoupler_tb;
  localparam int CELLS = 2;
  localparam int CNT_W = 4;
  localparam int CB    = 53;
  // each entry: [15:12] user cells pushed, [11:8] cell slots run, [7:0] seed base
  localparam logic [15:0] VEC [4] = '{16'h0300, 16'h1200, 16'h2420, 16'h2240};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, slot_en = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tx_vld, tx_soc, up_valid, up_soc;
  logic [7:0] tx_data, up_data;
  logic [CNT_W-1:0] tx_idle_cnt, rx_idle_cnt;

  always #5 clk = ~clk;

  cell_rate_decoupler #(.CELLS(CELLS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .slot_en(slot_en), .tx_vld(tx_vld), .tx_data(tx_data),
    .tx_soc(tx_soc), .tx_idle_cnt(tx_idle_cnt), .rx_valid(tx_vld),
    .rx_data(tx_data), .rx_soc(tx_soc), .up_valid(up_valid),
    .up_data(up_data), .up_soc(up_soc), .rx_idle_cnt(rx_idle_cnt)
  );

  int errors = 0, checks = 0, exp_idle = 0;
  bit done = 0;
  logic [7:0] tx_log_d [0:1023];
  logic       tx_log_s [0:1023];
  int tx_n = 0;
  logic [7:0] exp_up [0:511];
  int exp_up_n = 0, up_n = 0, up_err = 0;

  function automatic logic [7:0] cell_byte(input logic [7:0] s, input int i);
    if (s == 8'h00 && i < 4) return (i == 3) ? 8'h03 : 8'h00;
    return 8'(int'(s) * 31 + i * 5 + 1);
  endfunction

  function automatic logic [7:0] idle_exp(input int i);
    if (i < 3) return 8'h00;
    if (i == 3) return 8'h01;
    if (i == 4) return 8'h52;
    return 8'h6A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tx_vld && tx_n < 1024) begin
      tx_log_d[tx_n] = tx_data;
      tx_log_s[tx_n] = tx_soc;
      tx_n++;
    end
    if (up_valid) begin
      if (up_n >= exp_up_n || up_data != exp_up[up_n] || up_soc != (up_n % CB == 0))
        up_err++;
      up_n++;
    end
  end

  task automatic push_range(input logic [7:0] s, input int from, input int to);
    for (int i = from; i <= to; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1;
      in_data  = cell_byte(s, i);
      exp_up[exp_up_n] = cell_byte(s, i);
      exp_up_n++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_slots(input int n, input bit gap);
    tx_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slot_en = 1;
      if (gap) begin
        @(negedge clk);
        slot_en = 0;
      end
    end
    @(negedge clk);
    slot_en = 0;
    @(negedge clk);
  endtask

  task automatic check_cell(input int c, input bit user, input logic [7:0] s, input string req);
    int bad = 0;
    int first_bad = -1;
    for (int j = 0; j < CB; j++) begin
      logic [7:0] e;
      e = user ? cell_byte(s, j) : idle_exp(j);
      if (tx_log_d[c*CB+j] != e || tx_log_s[c*CB+j] != (j == 0)) begin
        bad++;
        if (first_bad < 0) first_bad = j;
      end
    end
    chk(bad == 0, req, $sformatf("cell %0d %s bytes wrong (first bad index)", c, user ? "user" : "idle"),
        first_bad, -1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] nu, nt;
    logic [7:0] sb;
    int acc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(tx_vld == 0 && up_valid == 0, "R10", "outputs idle in reset", int'(tx_vld), 0);
    chk(in_ready == 1, "R10", "in_ready in reset", int'(in_ready), 1);
    chk(tx_idle_cnt == 0 && rx_idle_cnt == 0, "R10", "counters in reset", int'(tx_idle_cnt), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 4; v++) begin
      nu = VEC[v][15:12];
      nt = VEC[v][11:8];
      sb = VEC[v][7:0];
      for (int c = 0; c < int'(nu); c++) push_range(sb + 8'(c), 0, CB - 1);
      run_slots(int'(nt) * CB, 0);
      chk(tx_n == int'(nt) * CB, "R1", "bytes emitted for slots", tx_n, int'(nt) * CB);
      for (int c = 0; c < int'(nt); c++)
        check_cell(c, c < int'(nu), sb + 8'(c), c < int'(nu) ? "R5" : "R3");
      exp_idle += int'(nt) - int'(nu);
      chk(tx_idle_cnt == 4'(exp_idle), "R7", "tx idle count", int'(tx_idle_cnt), exp_idle % 16);
    end

    // R4 partial cell is not split
    push_range(8'h60, 0, 29);
    run_slots(CB, 0);
    check_cell(0, 0, 8'h00, "R4");
    push_range(8'h60, 30, CB - 1);
    run_slots(CB, 0);
    check_cell(0, 1, 8'h60, "R4");
    exp_idle += 1;

    // R6 back-pressure limit
    acc = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!in_ready) break;
      in_valid = 1;
      in_data  = cell_byte(8'h70 + 8'(acc / CB), acc % CB);
      exp_up[exp_up_n] = in_data;
      exp_up_n++;
      acc++;
    end
    in_valid = 0;
    chk(acc == CELLS * CB, "R6", "bytes accepted before full", acc, CELLS * CB);
    chk(in_ready == 0, "R6", "in_ready low when full", int'(in_ready), 0);
    run_slots(2 * CB, 0);
    check_cell(0, 1, 8'h70, "R6");
    check_cell(1, 1, 8'h71, "R5");
    chk(in_ready == 1, "R6", "in_ready back after drain", int'(in_ready), 1);

    // R1 slots with gaps
    run_slots(CB, 1);
    chk(tx_n == CB, "R1", "bytes emitted with gapped slots", tx_n, CB);
    check_cell(0, 0, 8'h00, "R1");
    exp_idle += 1;

    // R7 wrap of the idle counter
    run_slots(10 * CB, 0);
    exp_idle += 10;
    chk(tx_idle_cnt == 4'(exp_idle), "R7", "tx idle count after wrap", int'(tx_idle_cnt), exp_idle % 16);

    // R8 R9 loopback receive results
    chk(up_n == exp_up_n, "R8", "upward bytes delivered", up_n, exp_up_n);
    chk(up_err == 0, "R8", "upward byte mismatches", up_err, 0);
    chk(rx_idle_cnt == 4'(exp_idle), "R9", "rx idle count after wrap", int'(rx_idle_cnt), exp_idle % 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule